// File: doc/BRIEF.md
# Microcoded Single-Bus Integer Core

This block is a multi-cycle integer processor in which every data movement crosses one shared 32-bit bus. A register file holding the 32 general registers and the program counter, the instruction register, two ALU operand latches, a memory address latch and the memory read port all hang on that bus. A microcode sequencer steps through a small control store; each microword names exactly one bus transfer by selecting a single driver and one or more loads, plus how the next microword is chosen.

An instruction starts with a four-step fetch that ends by writing PC+4 back through the ALU. The sequencer then jumps through a dispatch table indexed by the opcode into a short routine for register-register or register-immediate arithmetic, or back to fetch for any encoding it does not know. The memory is external: the core holds a read request for as long as the memory reports busy. Every register-file write is visible on a write-back port, which is how the surrounding system and the bench observe architectural progress.

Top module: `ucore_bus_core`

## Requirements
- R1: While rst_ni is low no memory request and no register write are presented, and mem_addr_o is zero; the first fetch after reset reads address RESET_PC (default 0), with mem_en_o high two cycles after reset is released.
- R2: Each instruction is fetched from the address held in the program counter, and in the fourth fetch step (third step after reset plus memory wait cycles) the program counter, register index 32, is written with that address plus 4.
- R3: A microword that accesses memory is repeated while mem_busy_i is high: mem_en_o and mem_addr_o stay unchanged, no register write happens, and each busy cycle lengthens the instruction by one cycle.
- R4: At most one source drives the internal bus in any cycle.
- R5: Opcode 0 (bits 31:26) with shamt (bits 10:6) zero is a register-register operation on rs (bits 25:21) and rt (bits 20:16) whose result goes to rd (bits 15:11), written three cycles after the PC write; funct (bits 5:0) 0x20 adds, 0x22 subtracts, 0x24 ands, 0x25 ors, 0x26 xors and 0x2a gives 1 if rs is less than rt as signed numbers, else 0.
- R6: Opcodes 0x08 (add) and 0x0a (signed set-less-than) use the immediate in bits 15:0 sign-extended and write rt three cycles after the PC write.
- R7: Opcodes 0x0c (and), 0x0d (or) and 0x0e (xor) use the immediate zero-extended and write rt.
- R8: Opcode 0x0f writes the immediate shifted left by 16 into rt, two cycles after the PC write.
- R9: Register 0 reads as zero; a write aimed at it changes nothing and is not reported on the write-back port.
- R10: Any other opcode, and opcode 0 with an unlisted funct or nonzero shamt, writes no register and starts the next fetch right after the PC write, so such an instruction takes four cycles plus memory waits.
- R11: wb_valid_o marks a register-file write taking effect at the next rising edge, with wb_idx_o the register index (1 to 31 general, 32 program counter) and wb_data_o the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Memory address latch contents |
| mem_wdata_o | output | 32 | Bus value offered as write data |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Read data, valid when mem_en_o is high and mem_busy_i is low |
| mem_busy_i | input | 1 | Memory not ready; the current access is held |
| wb_valid_o | output | 1 | Register-file write at the next edge |
| wb_idx_o | output | 6 | Index of the register written |
| wb_data_o | output | 32 | Value written |

## Verification
The assertions assume the memory treats mem_en_o as a held request: busy may be raised only while a request is present, and read data are taken to be valid in the first request cycle with busy low. They also assume the memory never keeps busy high forever. The bench memory model follows exactly this rule, counting a programmable number of wait cycles per request at the falling edge and presenting data only once that count is spent, and it never raises busy without a request.

// File: rtl/ucore_pkg.sv
package ucore_pkg;

  localparam int UPC_W = 4;

  typedef enum logic [2:0] {
    SEL_RS   = 3'd0,
    SEL_RT   = 3'd1,
    SEL_RD   = 3'd2,
    SEL_PC   = 3'd3,
    SEL_LINK = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    AS_INC4  = 2'd0,
    AS_FUNC  = 2'd1,
    AS_OPC   = 2'd2,
    AS_PASSB = 2'd3
  } alu_sel_e;

  // 0 sign, 1 zero, 2 upper half
  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_sel_e;

  typedef enum logic [1:0] {
    NX_SEQ   = 2'd0,
    NX_DISP  = 2'd1,
    NX_FETCH = 2'd2
  } next_e;

  typedef enum logic [2:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_SLT, AL_PASSB, AL_INC4
  } alu_op_e;

  // seventeen control lines
  typedef struct packed {
    reg_sel_e reg_sel;
    logic     en_reg;
    logic     reg_wr;
    logic     ld_a;
    logic     ld_b;
    logic     ld_ir;
    logic     ld_ma;
    alu_sel_e alu_sel;
    logic     en_alu;
    logic     en_mem;
    logic     mem_wr;
    ext_sel_e ext_sel;
    logic     en_imm;
  } ctrl_t;

  typedef struct packed {
    ctrl_t c;
    next_e nx;
    logic  wait_busy;
  } uinst_t;

  localparam logic [UPC_W-1:0] U_FETCH = 4'd0;
  localparam logic [UPC_W-1:0] U_RR    = 4'd4;
  localparam logic [UPC_W-1:0] U_IS    = 4'd7;
  localparam logic [UPC_W-1:0] U_IZ    = 4'd10;
  localparam logic [UPC_W-1:0] U_LUI   = 4'd13;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0a;
  localparam logic [5:0] OPC_ANDI = 6'h0c;
  localparam logic [5:0] OPC_ORI  = 6'h0d;
  localparam logic [5:0] OPC_XORI = 6'h0e;
  localparam logic [5:0] OPC_LUI  = 6'h0f;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2a;

  function automatic alu_op_e funct_op(input logic [5:0] f);
    case (f)
      FN_SUB:  return AL_SUB;
      FN_AND:  return AL_AND;
      FN_OR:   return AL_OR;
      FN_XOR:  return AL_XOR;
      FN_SLT:  return AL_SLT;
      default: return AL_ADD;
    endcase
  endfunction

  function automatic alu_op_e opc_op(input logic [5:0] o);
    case (o)
      OPC_SLTI: return AL_SLT;
      OPC_ANDI: return AL_AND;
      OPC_ORI:  return AL_OR;
      OPC_XORI: return AL_XOR;
      default:  return AL_ADD;
    endcase
  endfunction

  function automatic logic rr_legal(input logic [5:0] f, input logic [4:0] sh);
    logic known;
    known = (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
            (f == FN_OR)  || (f == FN_XOR) || (f == FN_SLT);
    return known && (sh == 5'd0);
  endfunction

endpackage

// File: rtl/ucore_urom.sv
module ucore_urom
  import ucore_pkg::*;
(
  input  logic [UPC_W-1:0] upc_i,
  output uinst_t           uinst_o
);

  always_comb begin
    uinst_o = '0;
    case (upc_i)
      // fetch
      4'd0: begin
        uinst_o.c.reg_sel = SEL_PC;
        uinst_o.c.en_reg  = 1'b1;
        uinst_o.c.ld_ma   = 1'b1;
      end
      4'd1: begin
        uinst_o.c.reg_sel = SEL_PC;
        uinst_o.c.en_reg  = 1'b1;
        uinst_o.c.ld_a    = 1'b1;
      end
      4'd2: begin
        uinst_o.c.en_mem  = 1'b1;
        uinst_o.c.ld_ir   = 1'b1;
        uinst_o.wait_busy = 1'b1;
      end
      4'd3: begin
        uinst_o.c.alu_sel = AS_INC4;
        uinst_o.c.en_alu  = 1'b1;
        uinst_o.c.reg_sel = SEL_PC;
        uinst_o.c.reg_wr  = 1'b1;
        uinst_o.nx        = NX_DISP;
      end
      // operand A from rs, shared by every arithmetic routine
      4'd4, 4'd7, 4'd10: begin
        uinst_o.c.reg_sel = SEL_RS;
        uinst_o.c.en_reg  = 1'b1;
        uinst_o.c.ld_a    = 1'b1;
      end
      4'd5: begin
        uinst_o.c.reg_sel = SEL_RT;
        uinst_o.c.en_reg  = 1'b1;
        uinst_o.c.ld_b    = 1'b1;
      end
      4'd6: begin
        uinst_o.c.alu_sel = AS_FUNC;
        uinst_o.c.en_alu  = 1'b1;
        uinst_o.c.reg_sel = SEL_RD;
        uinst_o.c.reg_wr  = 1'b1;
        uinst_o.nx        = NX_FETCH;
      end
      4'd8, 4'd11, 4'd13: begin
        uinst_o.c.en_imm  = 1'b1;
        uinst_o.c.ld_b    = 1'b1;
        uinst_o.c.ext_sel = (upc_i == 4'd8)  ? EXT_SIGN :
                            (upc_i == 4'd11) ? EXT_ZERO : EXT_UPPER;
      end
      4'd9, 4'd12: begin
        uinst_o.c.alu_sel = AS_OPC;
        uinst_o.c.en_alu  = 1'b1;
        uinst_o.c.reg_sel = SEL_RT;
        uinst_o.c.reg_wr  = 1'b1;
        uinst_o.nx        = NX_FETCH;
      end
      4'd14: begin
        uinst_o.c.alu_sel = AS_PASSB;
        uinst_o.c.en_alu  = 1'b1;
        uinst_o.c.reg_sel = SEL_RT;
        uinst_o.c.reg_wr  = 1'b1;
        uinst_o.nx        = NX_FETCH;
      end
      default: uinst_o.nx = NX_FETCH;
    endcase
  end

endmodule

// File: rtl/ucore_seq.sv
module ucore_seq
  import ucore_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] shamt_i,
  input  logic       mem_busy_i,
  output ctrl_t      ctrl_o
);

  logic [UPC_W-1:0] upc_q, upc_d, disp_tgt;
  uinst_t           uinst;
  logic             hold;

  ucore_urom u_urom (
    .upc_i  (upc_q),
    .uinst_o(uinst)
  );

  assign hold = uinst.wait_busy && mem_busy_i;

  always_comb begin
    case (opcode_i)
      OPC_RR:                      disp_tgt = rr_legal(funct_i, shamt_i) ? U_RR : U_FETCH;
      OPC_ADDI, OPC_SLTI:          disp_tgt = U_IS;
      OPC_ANDI, OPC_ORI, OPC_XORI: disp_tgt = U_IZ;
      OPC_LUI:                     disp_tgt = U_LUI;
      default:                     disp_tgt = U_FETCH;
    endcase
  end

  always_comb begin
    if (hold) begin
      upc_d = upc_q;
    end else begin
      case (uinst.nx)
        NX_SEQ:  upc_d = upc_q + 1'b1;
        NX_DISP: upc_d = disp_tgt;
        default: upc_d = U_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= U_FETCH;
    else         upc_q <= upc_d;
  end

  // a held microword keeps driving but changes no state
  always_comb begin
    ctrl_o = uinst.c;
    if (hold) begin
      ctrl_o.reg_wr = 1'b0;
      ctrl_o.ld_a   = 1'b0;
      ctrl_o.ld_b   = 1'b0;
      ctrl_o.ld_ir  = 1'b0;
      ctrl_o.ld_ma  = 1'b0;
      ctrl_o.mem_wr = 1'b0;
    end
  end

endmodule

// File: rtl/ucore_alu.sv
module ucore_alu
  import ucore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_sel_e        sel_i,
  input  logic [5:0]      funct_i,
  input  logic [5:0]      opcode_i,
  output logic [XLEN-1:0] y_o
);

  alu_op_e op;

  always_comb begin
    case (sel_i)
      AS_INC4: op = AL_INC4;
      AS_FUNC: op = funct_op(funct_i);
      AS_OPC:  op = opc_op(opcode_i);
      default: op = AL_PASSB;
    endcase
  end

  always_comb begin
    case (op)
      AL_ADD:  y_o = a_i + b_i;
      AL_SUB:  y_o = a_i - b_i;
      AL_AND:  y_o = a_i & b_i;
      AL_OR:   y_o = a_i | b_i;
      AL_XOR:  y_o = a_i ^ b_i;
      AL_SLT:  y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      AL_INC4: y_o = a_i + XLEN'(4);
      default: y_o = b_i;
    endcase
  end

endmodule

// File: rtl/ucore_rf.sv
module ucore_rf #(
  parameter int          XLEN     = 32,
  parameter int          NGPR     = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         IDX_W    = $clog2(NGPR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o
);

  // slots 0..NGPR-1 general, slot NGPR program counter
  logic [XLEN-1:0] regs_q [NGPR+1];
  logic            idx_ok;

  assign idx_ok  = (idx_i != '0) && (int'(idx_i) <= NGPR);
  assign rdata_o = idx_ok ? regs_q[idx_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NGPR; i++) regs_q[i] <= '0;
      regs_q[NGPR] <= XLEN'(RESET_PC);
    end else if (we_i && idx_ok) begin
      regs_q[idx_i] <= wdata_i;
    end
  end

endmodule

// File: rtl/ucore_bus_core.sv
module ucore_bus_core
  import ucore_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NGPR     = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         IDX_W    = $clog2(NGPR + 1),
  localparam int         IMM_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_busy_i,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]  wb_data_o
);

  ctrl_t            ctrl;
  logic [XLEN-1:0]  ir_q, a_q, b_q, ma_q;
  logic [XLEN-1:0]  bus, rf_rdata, alu_y, imm_ext;
  logic [IDX_W-1:0] idx;
  logic [3:0]       drv;

  ucore_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .opcode_i  (ir_q[31:26]),
    .funct_i   (ir_q[5:0]),
    .shamt_i   (ir_q[10:6]),
    .mem_busy_i(mem_busy_i),
    .ctrl_o    (ctrl)
  );

  always_comb begin
    case (ctrl.reg_sel)
      SEL_RS:   idx = IDX_W'(ir_q[25:21]);
      SEL_RT:   idx = IDX_W'(ir_q[20:16]);
      SEL_RD:   idx = IDX_W'(ir_q[15:11]);
      SEL_PC:   idx = IDX_W'(NGPR);
      SEL_LINK: idx = IDX_W'(NGPR - 1);
      default:  idx = '0;
    endcase
  end

  ucore_rf #(
    .XLEN    (XLEN),
    .NGPR    (NGPR),
    .RESET_PC(RESET_PC)
  ) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .we_i   (ctrl.reg_wr),
    .wdata_i(bus),
    .rdata_o(rf_rdata)
  );

  ucore_alu #(
    .XLEN(XLEN)
  ) u_alu (
    .a_i     (a_q),
    .b_i     (b_q),
    .sel_i   (ctrl.alu_sel),
    .funct_i (ir_q[5:0]),
    .opcode_i(ir_q[31:26]),
    .y_o     (alu_y)
  );

  always_comb begin
    case (ctrl.ext_sel)
      EXT_SIGN:  imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
      EXT_UPPER: imm_ext = {ir_q[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
      default:   imm_ext = {{(XLEN-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};
    endcase
  end

  // one-hot source enables merged into the bus
  assign drv = {ctrl.en_reg, ctrl.en_alu, ctrl.en_imm, ctrl.en_mem};

  always_comb begin
    bus = '0;
    if (drv[3]) bus = bus | rf_rdata;
    if (drv[2]) bus = bus | alu_y;
    if (drv[1]) bus = bus | imm_ext;
    if (drv[0]) bus = bus | mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ctrl.ld_ir) ir_q <= bus;
      if (ctrl.ld_a)  a_q  <= bus;
      if (ctrl.ld_b)  b_q  <= bus;
      if (ctrl.ld_ma) ma_q <= bus;
    end
  end

  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus;
  assign mem_en_o    = ctrl.en_mem;
  assign mem_we_o    = ctrl.mem_wr;

  assign wb_valid_o  = ctrl.reg_wr && (idx != '0);
  assign wb_idx_o    = idx;
  assign wb_data_o   = bus;

endmodule

// File: rtl/ucore_chk.sv
module ucore_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  parameter int NGPR  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic             mem_en_o,
  input logic             mem_busy_i,
  input logic             wb_valid_o,
  input logic [IDX_W-1:0] wb_idx_o,
  input logic [XLEN-1:0]  wb_data_o,
  input logic [3:0]       drv_i
);

  logic pc_wr;
  assign pc_wr = wb_valid_o && (int'(wb_idx_o) == NGPR);

  a_r4_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_i));

  a_r3_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_busy_i |=> mem_en_o && $stable(mem_addr_o));

  a_r3_no_write_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_busy_i |-> !wb_valid_o);

  a_r2_pc_plus4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr |-> wb_data_o == mem_addr_o + XLEN'(4));

  a_r2_single_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr |=> !pc_wr);

endmodule

bind ucore_bus_core ucore_chk #(
  .XLEN (XLEN),
  .IDX_W(IDX_W),
  .NGPR (NGPR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_addr_o(mem_addr_o),
  .mem_en_o  (mem_en_o),
  .mem_busy_i(mem_busy_i),
  .wb_valid_o(wb_valid_o),
  .wb_idx_o  (wb_idx_o),
  .wb_data_o (wb_data_o),
  .drv_i     (drv)
);

// File: tb/tb_ucore_bus_core.sv
module tb_ucore_bus_core;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, wb_data_o;
  logic        mem_en_o, mem_we_o, mem_busy_i, wb_valid_o;
  logic [5:0]  wb_idx_o;

  logic [31:0] mem [64];
  int          lat, wcnt, cyc, ev_n, n_chk, n_bad;
  bit          rec;
  logic [5:0]  ev_idx [64];
  logic [31:0] ev_dat [64];
  int          ev_cyc [64];

  always #5 clk = ~clk;

  ucore_bus_core dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_rdata_i(mem_rdata_i),
    .mem_busy_i (mem_busy_i),
    .wb_valid_o (wb_valid_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o)
  );

  // memory: lat busy cycles per request, data with busy low
  always @(negedge clk) begin
    if (mem_en_o) begin
      if (wcnt < lat) begin
        mem_busy_i = 1'b1;
        wcnt++;
      end else begin
        mem_busy_i  = 1'b0;
        mem_rdata_i = mem[mem_addr_o[7:2]];
      end
    end else begin
      wcnt       = 0;
      mem_busy_i = 1'b0;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rec && wb_valid_o && ev_n < 64) begin
      ev_idx[ev_n] = wb_idx_o;
      ev_dat[ev_n] = wb_data_o;
      ev_cyc[ev_n] = cyc;
      ev_n++;
    end
  end

  always @(posedge clk) if (rec) cyc++;

  function automatic logic [31:0] r_op(logic [5:0] f, int rd, int rs, int rt, int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), f};
  endfunction

  function automatic logic [31:0] i_op(logic [5:0] op, int rt, int rs, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic start(int l);
    rst_ni = 1'b0;
    rec    = 1'b0;
    lat    = l;
    repeat (2) @(negedge clk);
    ev_n       = 0;
    cyc        = 0;
    wcnt       = 0;
    mem_busy_i = 1'b0;
    rst_ni     = 1'b1;
    rec        = 1'b1;
  endtask

  function automatic int nth(int k, bit want_pc);
    int c = 0;
    for (int i = 0; i < ev_n; i++) begin
      if ((ev_idx[i] == 6'd32) == want_pc) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  task automatic chk_gpr(string req, int k, int idx, logic [31:0] d);
    int e = nth(k, 1'b0);
    check(req, (e < 0) ? 64'hdead : {26'b0, ev_idx[e], ev_dat[e]}, {26'b0, 6'(idx), d});
  endtask

  task automatic chk_pc(string req, int k, logic [31:0] d, int c);
    int e = nth(k, 1'b1);
    check(req, (e < 0) ? 64'hdead : {ev_dat[e], 32'(ev_cyc[e])}, {d, 32'(c)});
  endtask

  task automatic chk_gap(string req, int k, int gap);
    int p = nth(k, 1'b1);
    int g = nth(k, 1'b0);
    check(req, (p < 0 || g < 0) ? 64'hdead : 64'(ev_cyc[g] - ev_cyc[p]), 64'(gap));
  endtask

  task automatic t_reset();
    clear_mem();
    rst_ni = 1'b0;
    lat    = 0;
    repeat (2) @(negedge clk);
    #2;
    check("R1 en in reset", 64'(mem_en_o), 64'd0);
    check("R1 wb in reset", 64'(wb_valid_o), 64'd0);
    check("R1 addr in reset", 64'(mem_addr_o), 64'd0);
    start(0);
    repeat (2) @(negedge clk);
    #2;
    check("R1 first fetch", {31'b0, mem_en_o, mem_addr_o}, {31'b0, 1'b1, 32'h0});
  endtask

  task automatic t_rtype();
    clear_mem();
    mem[0] = i_op(6'h08, 1, 0, 16'h0005);
    mem[1] = i_op(6'h08, 2, 0, 16'hfffd);
    mem[2] = r_op(6'h20, 3, 1, 2, 0);
    mem[3] = r_op(6'h22, 4, 1, 2, 0);
    mem[4] = r_op(6'h2a, 5, 2, 1, 0);
    mem[5] = r_op(6'h24, 6, 1, 2, 0);
    mem[6] = r_op(6'h25, 7, 1, 2, 0);
    mem[7] = r_op(6'h26, 8, 1, 2, 0);
    mem[8] = r_op(6'h2a, 9, 1, 2, 0);
    start(0);
    repeat (80) @(negedge clk);
    chk_pc("R2 first pc write", 0, 32'h4, 3);
    chk_gpr("R6 addi pos", 0, 1, 32'h5);
    chk_gpr("R6 addi neg", 1, 2, 32'hfffffffd);
    chk_gpr("R5 R4 add", 2, 3, 32'h2);
    chk_gpr("R5 sub", 3, 4, 32'h8);
    chk_gpr("R5 slt true", 4, 5, 32'h1);
    chk_gpr("R5 and", 5, 6, 32'h5);
    chk_gpr("R5 or", 6, 7, 32'hfffffffd);
    chk_gpr("R5 xor", 7, 8, 32'hfffffff8);
    chk_gpr("R5 slt false", 8, 9, 32'h0);
    chk_gap("R5 rr latency", 2, 3);
    chk_pc("R2 pc after 3", 3, 32'h10, 3 + 7 * 3);
  endtask

  task automatic t_imm();
    clear_mem();
    mem[0] = i_op(6'h0d, 1, 0, 16'h8000);
    mem[1] = i_op(6'h08, 2, 0, 16'h8000);
    mem[2] = i_op(6'h0f, 3, 0, 16'h1234);
    mem[3] = i_op(6'h0c, 4, 2, 16'hf0f0);
    mem[4] = i_op(6'h0e, 5, 1, 16'hffff);
    mem[5] = i_op(6'h0a, 6, 2, 16'h0001);
    mem[6] = i_op(6'h0a, 7, 1, 16'hffff);
    start(0);
    repeat (60) @(negedge clk);
    chk_gpr("R7 ori zext", 0, 1, 32'h00008000);
    chk_gpr("R6 addi sext", 1, 2, 32'hffff8000);
    chk_gpr("R8 lui", 2, 3, 32'h12340000);
    chk_gpr("R7 andi", 3, 4, 32'h00008000);
    chk_gpr("R7 xori", 4, 5, 32'h00007fff);
    chk_gpr("R6 slti true", 5, 6, 32'h1);
    chk_gpr("R6 slti false", 6, 7, 32'h0);
    chk_gap("R8 lui latency", 2, 2);
    chk_gap("R6 imm latency", 1, 3);
  endtask

  task automatic t_r0();
    int zero_wr = 0;
    clear_mem();
    mem[0] = i_op(6'h08, 0, 0, 16'h0007);
    mem[1] = r_op(6'h20, 1, 0, 0, 0);
    mem[2] = i_op(6'h0d, 2, 0, 16'h0055);
    start(0);
    repeat (40) @(negedge clk);
    for (int i = 0; i < ev_n; i++) if (ev_idx[i] == 6'd0) zero_wr++;
    check("R9 R11 no r0 report", 64'(zero_wr), 64'd0);
    chk_gpr("R9 r0 reads zero", 0, 1, 32'h0);
    chk_gpr("R9 r0 as source", 1, 2, 32'h55);
    chk_pc("R11 pc index", 1, 32'h8, 10);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = 32'hfc000000;
    mem[1] = r_op(6'h20, 4, 1, 1, 1);
    mem[2] = r_op(6'h21, 5, 1, 1, 0);
    mem[3] = i_op(6'h08, 3, 0, 16'h0009);
    start(0);
    repeat (40) @(negedge clk);
    chk_pc("R10 bad opcode", 1, 32'h8, 7);
    chk_pc("R10 nonzero shamt", 2, 32'hc, 11);
    chk_pc("R10 bad funct", 3, 32'h10, 15);
    chk_gpr("R10 no write", 0, 3, 32'h9);
  endtask

  task automatic t_busy();
    clear_mem();
    mem[0] = i_op(6'h08, 1, 0, 16'h000b);
    mem[1] = r_op(6'h20, 2, 1, 1, 0);
    start(3);
    repeat (40) @(negedge clk);
    chk_pc("R3 wait first", 0, 32'h4, 6);
    chk_gpr("R3 data after wait", 0, 1, 32'hb);
    chk_pc("R3 wait second", 1, 32'h8, 16);
    chk_gpr("R3 rr after wait", 1, 2, 32'h16);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rec   = 1'b0;
    ev_n  = 0;
    cyc   = 0;
    wcnt  = 0;
    mem_busy_i  = 1'b0;
    mem_rdata_i = 32'h0;
    t_reset();
    t_rtype();
    t_imm();
    t_r0();
    t_nop();
    t_busy();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all: watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule